// File: doc/BRIEF.md
# Requantizing Fixed-Point Matrix Multiplier

This block forms C = A x B for a signed 16-bit A of M rows by N columns and a signed 16-bit B of N rows by P columns. Every element of C comes from a 32-bit multiply-accumulate that wraps on overflow. A 16-bit window of that sum is then taken as the output sample. The caller selects the window by stating how many fractional bits A, B and the result carry, or by naming one of two fixed windows.

Operands enter through a valid/ready load port, one element per transfer. The port raises ready only while the engine is idle. During a run ready is low, and any element offered is dropped and not held back for later. A one-cycle start pulse begins a run. The engine performs one multiply-accumulate per clock and walks C row by row, with the inner sum index running fastest. A single-cycle done pulse marks the end of the run, after which the results can be read through a combinational indexed read port.

Top module: `qmat_mul`

## Requirements
- R1: After reset busy and done are 0, wr_ready is 1 and every result element reads 0.
- R2: A load transfer (wr_valid and wr_ready both high) writes wr_data into A when wr_sel is 0 and into B when wr_sel is 1, at [wr_row][wr_col]. A transfer whose index is outside that matrix is dropped. A read of C outside M x P returns 0.
- R3: wr_ready is 0 while busy. A load offered during a run changes no operand.
- R4: Each C[i][j] is computed from the 32-bit sum over k of A[i][k]*B[k][j], wrapped modulo 2^32. done rises exactly M*N*P clock edges after the edge that accepts start.
- R5: done is high for exactly one cycle per run.
- R6: A start pulse during a run is ignored and does not lengthen or restart the run.
- R7: With fa, fb and fo as the fractional-bit counts and d = fa + fb - F, the output is the 32-bit sum arithmetically shifted right by d and truncated to 16 bits. A negative d means a left shift with zero fill. F is fa for mode 0, fb for mode 1 and frac_out for mode 4.
- R8: Mode 2 and the unused codes 5, 6 and 7 output sum bits 31:16. Mode 3 outputs sum bits 30:15, so with fa = fb = 15 it gives the same result as mode 0.
- R9: mode, frac_a, frac_b and frac_out are sampled on the cycle start is accepted. Changing them during a run has no effect on that run.
- R10: A load transfer accepted in the same cycle as start is visible to the run that start begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Load element offered |
| wr_ready | output | 1 | Load port accepts (idle only) |
| wr_sel | input | 1 | 0 selects A, 1 selects B |
| wr_row | input | XW | Row index of the loaded element |
| wr_col | input | XW | Column index of the loaded element |
| wr_data | input | 16 | Signed element value |
| start | input | 1 | Run request pulse |
| mode | input | 3 | Window selection code |
| frac_a | input | 5 | Fractional bits of A |
| frac_b | input | 5 | Fractional bits of B |
| frac_out | input | 5 | Requested output fractional bits (mode 4) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_row | input | XW | Result row to read |
| rd_col | input | XW | Result column to read |
| rd_data | output | 16 | Result element, combinational |

XW is clog2 of the largest of M, N and P, with a minimum of 1.

## Verification
A load transfer and an accepted start can occur in the same cycle. The bench provokes this by holding wr_valid with a fresh A element on the start cycle. It then requires every result to match a model that already contains the new value. The second overlap is a start pulse, a load attempt and a change of mode and fractional counts, all held through a whole run. For that case the bench checks the run length, that wr_ready stays low, and that the results still follow the operands and settings present when the run began.

// File: rtl/qmm_pkg.sv
package qmm_pkg;
  typedef logic signed [15:0] sample_t;
  typedef logic signed [31:0] acc_t;

  typedef enum logic [2:0] {
    QM_MATCH_A   = 3'd0,
    QM_MATCH_B   = 3'd1,
    QM_HIGH_ACC  = 3'd2,
    QM_HIGH_PROD = 3'd3,
    QM_USER      = 3'd4
  } qmode_e;

  typedef struct packed {
    logic [2:0] mode;
    logic [4:0] fa;
    logic [4:0] fb;
    logic [4:0] fo;
  } qcfg_t;
endpackage

// File: rtl/qmm_bank.sv
module qmm_bank
  import qmm_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 4,
  parameter int XW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [XW-1:0] w_row,
  input  logic [XW-1:0] w_col,
  input  sample_t       w_data,
  input  logic [XW-1:0] r_row,
  input  logic [XW-1:0] r_col,
  output sample_t       r_data
);
  sample_t cells [ROWS][COLS];

  logic w_in_range, r_in_range;
  assign w_in_range = (int'(w_row) < ROWS) && (int'(w_col) < COLS);
  assign r_in_range = (int'(r_row) < ROWS) && (int'(r_col) < COLS);

  for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
    for (genvar gc = 0; gc < COLS; gc++) begin : g_col
      always_ff @(posedge clk) begin
        if (!rst_n)
          cells[gr][gc] <= '0;
        else if (we && w_in_range && int'(w_row) == gr && int'(w_col) == gc)
          cells[gr][gc] <= w_data;
      end
    end
  end

  always_comb begin
    r_data = '0;
    for (int rr = 0; rr < ROWS; rr++)
      for (int cc = 0; cc < COLS; cc++)
        if (r_in_range && int'(r_row) == rr && int'(r_col) == cc)
          r_data = cells[rr][cc];
  end
endmodule

// File: rtl/qmm_seq.sv
module qmm_seq #(
  parameter int M  = 3,
  parameter int N  = 4,
  parameter int P  = 2,
  parameter int XW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [XW-1:0] idx_i,
  output logic [XW-1:0] idx_j,
  output logic [XW-1:0] idx_k,
  output logic          first_k,
  output logic          last_k
);
  localparam logic [XW-1:0] I_LAST = XW'(M - 1);
  localparam logic [XW-1:0] J_LAST = XW'(P - 1);
  localparam logic [XW-1:0] K_LAST = XW'(N - 1);

  logic last_all;
  assign first_k  = (idx_k == '0);
  assign last_k   = (idx_k == K_LAST);
  assign last_all = last_k && (idx_j == J_LAST) && (idx_i == I_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      idx_i <= '0;
      idx_j <= '0;
      idx_k <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          idx_i <= '0;
          idx_j <= '0;
          idx_k <= '0;
        end
      end else if (!last_k) begin
        idx_k <= idx_k + 1'b1;
      end else begin
        idx_k <= '0;
        if (idx_j != J_LAST) begin
          idx_j <= idx_j + 1'b1;
        end else begin
          idx_j <= '0;
          if (idx_i != I_LAST) begin
            idx_i <= idx_i + 1'b1;
          end else begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_all) |=> busy); // R6
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(idx_i) < M && int'(idx_j) < P && int'(idx_k) < N)); // R4
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R4
endmodule

// File: rtl/qmm_requant.sv
module qmm_requant
  import qmm_pkg::*;
(
  input  acc_t    acc,
  input  qcfg_t   cfg,
  output sample_t q
);
  logic signed [7:0]  shift_d;
  logic        [7:0]  left_amt;
  logic signed [63:0] wide;
  logic signed [63:0] moved;
  logic        [4:0]  f_sel;

  always_comb begin
    f_sel = cfg.fo;
    case (cfg.mode)
      QM_MATCH_A: f_sel = cfg.fa;
      QM_MATCH_B: f_sel = cfg.fb;
      default:    f_sel = cfg.fo;
    endcase
    case (cfg.mode)
      QM_MATCH_A, QM_MATCH_B, QM_USER:
        shift_d = $signed({3'b000, cfg.fa}) + $signed({3'b000, cfg.fb})
                - $signed({3'b000, f_sel});
      QM_HIGH_PROD: shift_d = 8'sd15;
      default:      shift_d = 8'sd16;
    endcase
    left_amt = 8'(-shift_d);
    wide     = {{32{acc[31]}}, acc};
    if (shift_d[7])
      moved = wide << left_amt[5:0];
    else
      moved = wide >>> shift_d[6:0];
    q = moved[15:0];
  end

  always_comb begin
    if (cfg.mode == QM_HIGH_ACC)
      AST_HIGH_WINDOW: assert (q == acc[31:16]); // R8
  end
endmodule

// File: rtl/qmat_mul.sv
module qmat_mul
  import qmm_pkg::*;
#(
  parameter int M = 3,
  parameter int N = 4,
  parameter int P = 2,
  localparam int DMAX = (M > N) ? ((M > P) ? M : P) : ((N > P) ? N : P),
  localparam int XW   = (DMAX > 1) ? $clog2(DMAX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          wr_sel,
  input  logic [XW-1:0] wr_row,
  input  logic [XW-1:0] wr_col,
  input  logic [15:0]   wr_data,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [4:0]    frac_a,
  input  logic [4:0]    frac_b,
  input  logic [4:0]    frac_out,
  output logic          busy,
  output logic          done,
  input  logic [XW-1:0] rd_row,
  input  logic [XW-1:0] rd_col,
  output logic [15:0]   rd_data
);
  logic [XW-1:0] idx_i, idx_j, idx_k;
  logic          first_k, last_k;
  logic          load_fire;
  sample_t       a_val, b_val, c_val, q_val;
  acc_t          acc_q, acc_next, prod;
  qcfg_t         cfg_q;

  qmm_seq #(.M(M), .N(N), .P(P), .XW(XW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .idx_i(idx_i), .idx_j(idx_j), .idx_k(idx_k),
    .first_k(first_k), .last_k(last_k)
  );

  assign wr_ready  = !busy;
  assign load_fire = wr_valid && wr_ready;

  qmm_bank #(.ROWS(M), .COLS(N), .XW(XW)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .we(load_fire && !wr_sel),
    .w_row(wr_row), .w_col(wr_col), .w_data(sample_t'(wr_data)),
    .r_row(idx_i), .r_col(idx_k), .r_data(a_val)
  );

  qmm_bank #(.ROWS(N), .COLS(P), .XW(XW)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .we(load_fire && wr_sel),
    .w_row(wr_row), .w_col(wr_col), .w_data(sample_t'(wr_data)),
    .r_row(idx_k), .r_col(idx_j), .r_data(b_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (start && !busy)
      cfg_q <= '{mode: mode, fa: frac_a, fb: frac_b, fo: frac_out};
  end

  assign prod     = a_val * b_val;
  assign acc_next = (first_k ? acc_t'(0) : acc_q) + prod;

  always_ff @(posedge clk) begin
    if (!rst_n)
      acc_q <= '0;
    else if (busy)
      acc_q <= acc_next;
  end

  qmm_requant u_requant (.acc(acc_next), .cfg(cfg_q), .q(q_val));

  qmm_bank #(.ROWS(M), .COLS(P), .XW(XW)) u_bank_c (
    .clk(clk), .rst_n(rst_n), .we(busy && last_k),
    .w_row(idx_i), .w_col(idx_j), .w_data(q_val),
    .r_row(rd_row), .r_col(rd_col), .r_data(c_val)
  );

  assign rd_data = c_val;

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q)); // R9
  AST_SUM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && first_k) |=> (acc_q == $past(prod))); // R4
  AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(u_bank_a.cells[0][0])); // R3
endmodule

// File: tb/qmat_mul_test.sv
`timescale 1ns/1ps
module qmat_mul_test;
  localparam int M = 3, N = 4, P = 2, XW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, wr_sel = 0, start = 0;
  logic [XW-1:0] wr_row = 0, wr_col = 0, rd_row = 0, rd_col = 0;
  logic [15:0] wr_data = 0;
  logic [2:0] mode = 0;
  logic [4:0] frac_a = 0, frac_b = 0, frac_out = 0;
  logic wr_ready, busy, done;
  logic [15:0] rd_data;

  int ma [M][N];
  int mb [N][P];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  qmat_mul #(.M(M), .N(N), .P(P)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
    .start(start), .mode(mode), .frac_a(frac_a), .frac_b(frac_b),
    .frac_out(frac_out), .busy(busy), .done(done),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int expect_c(int i, int j, int md, int fa, int fb, int fo);
    longint sum = 0;
    longint ext;
    logic signed [31:0] w;
    int f, d;
    logic [15:0] r;
    for (int k = 0; k < N; k++) sum += longint'(ma[i][k]) * longint'(mb[k][j]);
    w = sum[31:0];
    ext = longint'(w);
    f = (md == 0) ? fa : (md == 1) ? fb : fo;
    if (md == 0 || md == 1 || md == 4) d = fa + fb - f;
    else if (md == 3) d = 15;
    else d = 16;
    if (d >= 0) ext = ext >>> d; else ext = ext << (-d);
    r = ext[15:0];
    return int'($signed(r));
  endfunction

  task automatic put(input bit sel, input int row, input int col, input int val);
    @(negedge clk);
    wr_valid = 1; wr_sel = sel; wr_row = XW'(row); wr_col = XW'(col);
    wr_data = 16'(val);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic load_all();
    for (int i = 0; i < M; i++) for (int k = 0; k < N; k++) put(0, i, k, ma[i][k]);
    for (int k = 0; k < N; k++) for (int j = 0; j < P; j++) put(1, k, j, mb[k][j]);
  endtask

  task automatic fill_rand();
    for (int i = 0; i < M; i++) for (int k = 0; k < N; k++)
      ma[i][k] = int'($signed(16'($urandom())));
    for (int k = 0; k < N; k++) for (int j = 0; j < P; j++)
      mb[k][j] = int'($signed(16'($urandom())));
  endtask

  task automatic run(input string tag, input int md, input int fa, input int fb,
                     input int fo, input bit disturb, input bit conc);
    int cyc = 0;
    @(negedge clk);
    start = 1; mode = 3'(md); frac_a = 5'(fa); frac_b = 5'(fb); frac_out = 5'(fo);
    if (conc) begin  // R10: load in the start cycle
      wr_valid = 1; wr_sel = 0; wr_row = 1; wr_col = 2; wr_data = 16'd777;
      ma[1][2] = 777;
    end
    @(negedge clk);
    start = 0; wr_valid = 0;
    if (disturb) begin  // R6 R9 R3: noise during the run
      start = 1; mode = 3'(md + 1); frac_a = 5'(fa + 3); frac_out = 5'(fo + 1);
      wr_valid = 1; wr_sel = 0; wr_row = 0; wr_col = 0; wr_data = 16'd1234;
    end
    while (!done && cyc < 1000) begin
      if (disturb && cyc == 0) chk("R3 wr_ready low while busy", wr_ready, 0);
      @(negedge clk);
      cyc++;
    end
    start = 0; wr_valid = 0;
    chk({tag, " R4 run length"}, cyc, M * N * P);
    @(negedge clk);
    chk({tag, " R5 done one cycle"}, done, 0);
    for (int i = 0; i < M; i++)
      for (int j = 0; j < P; j++) begin
        rd_row = XW'(i); rd_col = XW'(j);
        #1;
        chk(tag, int'($signed(rd_data)), expect_c(i, j, md, fa, fb, fo));
      end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 wr_ready", wr_ready, 1);
    for (int i = 0; i < M; i++)
      for (int j = 0; j < P; j++) begin
        rd_row = XW'(i); rd_col = XW'(j); #1;
        chk("R1 result zero", rd_data, 0);
      end
    rd_row = 2'd3; rd_col = 0; #1;
    chk("R2 read outside zero", rd_data, 0);

    // R2 R7 R8: random data across every mode code
    for (int t = 0; t < 8; t++) begin
      fill_rand();
      load_all();
      if (t == 0) put(0, 3, 0, 16'h7fff);  // R2: out of range, dropped
      run("R7 R8 random", t, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
          int'($urandom_range(0, 31)), 0, 0);
    end

    // R8: Q.15 operands, high-product window equals match-A
    fill_rand(); load_all();
    run("R8 high prod q15", 3, 15, 15, 0, 0, 0);
    run("R8 match A q15", 0, 15, 15, 0, 0, 0);

    // R4: wrap of the sum: four products of 2^30 sum to 2^32
    for (int i = 0; i < M; i++) for (int k = 0; k < N; k++) ma[i][k] = -32768;
    for (int k = 0; k < N; k++) for (int j = 0; j < P; j++) mb[k][j] = -32768;
    load_all();
    run("R4 wrap", 2, 0, 0, 0, 0, 0);
    chk("R4 wrap value", expect_c(0, 0, 2, 0, 0, 0), 0);

    // R7: negative offset (left shift) and large offset (sign only)
    fill_rand();
    for (int i = 0; i < M; i++) for (int k = 0; k < N; k++) ma[i][k] = ma[i][k] % 7;
    load_all();
    run("R7 left shift", 4, 0, 0, 20, 0, 0);
    run("R7 deep right", 4, 31, 31, 0, 0, 0);
    run("R7 match B", 1, 3, 5, 0, 0, 0);

    // R3 R6 R9: start, load and setting changes held through a run
    fill_rand(); load_all();
    run("R6 R9 disturbed", 4, 9, 6, 4, 1, 0);

    // R10: load and start in the same cycle
    run("R10 concurrent load", 0, 4, 8, 0, 0, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule